// File: doc/BRIEF.md
# LPC Bus-Master Request Handler

This block sits on the host side of an LPC bus and serves two peripherals that can take over the bus as bus masters. Each peripheral has its own active-low request line. On that line it sends a short serial message to ask for the bus or to withdraw the request. When a request is pending and the host is free, the handler chooses a winner and grants the bus. The grant is a START nibble on the LAD lines, one code per master, framed by LFRAME# going low for one clock.

After the grant, the peripheral drives the rest of the cycle: a cycle-type nibble, an address of `ADDR_NIBBLES` nibbles, a size nibble and, for writes, two data nibbles. The handler checks every field. Only memory read and memory write are legal, so an I/O cycle or any other type is refused. An address outside the window `[ADDR_LO, ADDR_HI]` is refused, and so is a size other than one byte. A refused cycle is aborted: LFRAME# is held low and LAD carries all ones for `ABORT_CYCLES` clocks. A legal cycle becomes one request on a valid/ready memory port. For a read, the returned byte is then put back on LAD. A ready-ok SYNC nibble closes every legal cycle.

The memory port follows stream rules. While `mem_valid` is high and `mem_ready` is low, the handler keeps the address, direction and write data unchanged. The request completes on the first clock where both are high. On a read, `mem_rdata` is taken in that same clock. `host_busy` is a plain control input: while it is high, no new grant starts.

Top module: `lpc_bm_host`

## Requirements
- R1: A request line idles high. A message is a 0 start bit, then three channel bits with the most significant bit first, then an action bit. Channel 100b with action bit 1 marks that master's request as pending. Channel 100b with action bit 0 withdraws the pending request.
- R2: A message with any channel value other than 100b leaves the pending state unchanged, so no grant follows it.
- R3: A grant holds `lframe_n` low for exactly one clock while `lad_out` drives START. START is 0010b for master 0 and 0011b for master 1.
- R4: When both masters are pending at the moment of a grant, a round-robin pointer chooses the winner. The pointer favours master 0 after reset and toggles after every contended grant. A grant made with only one master pending does not move the pointer.
- R5: A grant starts only while no bus cycle or abort is running and `host_busy` is low.
- R6: The cycle-type nibble must be 0100b (memory read) or 0110b (memory write). Every other value, including the I/O codes 0000b and 0010b, causes an abort.
- R7: The address is sent most significant nibble first. If it lies outside `[ADDR_LO, ADDR_HI]`, the cycle is aborted after the size nibble.
- R8: A size nibble other than 0000b causes an abort.
- R9: During an abort, `lframe_n` stays low and `lad_out` is 1111b with `lad_oe` high, for exactly `ABORT_CYCLES` clocks. The bus then goes idle for at least one clock before any new grant.
- R10: A legal cycle raises `mem_valid` with the address, the direction (`mem_write` = 1 for write) and the write byte, which is assembled from the low nibble sent first. All of these stay stable until `mem_ready` is seen high.
- R11: After a read handshake, `lad_out` carries the returned byte for two clocks, low nibble first. Every legal cycle then ends with one clock of SYNC 0000b, after which `lad_oe` is released.
- R12: After reset, `lframe_n` is high, `lad_oe` and `mem_valid` are low, and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ldrq_n | input | 2 | Serial request lines, bit i for master i |
| host_busy | input | 1 | High while a host-initiated cycle owns the bus |
| lad_in | input | 4 | LAD nibble driven by the peripheral |
| lad_out | output | 4 | LAD nibble driven by the handler |
| lad_oe | output | 1 | Output enable for `lad_out` |
| lframe_n | output | 1 | Active-low frame strobe |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory port accepts the request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 4*ADDR_NIBBLES | Memory address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, taken at the handshake |

## Verification
The bench builds the handler with a 16-bit address (`ADDR_NIBBLES` = 4), the window 1000h to 7FFFh and `ABORT_CYCLES` = 4. With a 16-bit address, every one of the sixteen cycle-type codes and every one of the sixteen size codes can be run as a full bus cycle. Both edges of the address window can be probed exactly, one step inside and one step outside, with reads and with writes. The short abort length lets the bench follow every low frame clock by clock. It can also show that a master still pending during an abort is granted only after the idle clock.

// File: rtl/lpc_bm_pkg.sv
package lpc_bm_pkg;
  localparam logic [2:0] CH_BUSMASTER = 3'b100;
  localparam logic [3:0] CT_MEM_RD    = 4'b0100;
  localparam logic [3:0] CT_MEM_WR    = 4'b0110;
  localparam logic [2:0] START_HI     = 3'b001;
  localparam logic [3:0] NIB_ABORT    = 4'b1111;
  localparam logic [3:0] NIB_SYNC_OK  = 4'b0000;
  localparam logic [3:0] SIZE_BYTE    = 4'b0000;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_CYC, ST_ADDR, ST_SIZE,
    ST_WDATA, ST_MEM, ST_RDATA, ST_SYNC, ST_ABORT
  } bm_state_e;
endpackage

// File: rtl/lpc_ldrq_rx.sv
module lpc_ldrq_rx
  import lpc_bm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ldrq_n,
  input  logic clr,
  output logic pend
);
  logic [2:0] bit_cnt;
  logic [2:0] chan;
  logic       msg_done;

  assign msg_done = (bit_cnt == 3'd4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= 3'd0;
      chan    <= 3'd0;
      pend    <= 1'b0;
    end else begin
      if (bit_cnt == 3'd0) begin
        if (!ldrq_n) bit_cnt <= 3'd1;
      end else if (!msg_done) begin
        chan    <= {chan[1:0], ldrq_n};
        bit_cnt <= bit_cnt + 3'd1;
      end else begin
        bit_cnt <= 3'd0;
      end
      if (msg_done && chan == CH_BUSMASTER) pend <= ldrq_n;
      else if (clr)                         pend <= 1'b0;
    end
  end

  // R2: messages on other channels must not disturb the pending flag
  p_ignore_other_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_done && chan != CH_BUSMASTER && !clr) |=> (pend == $past(pend)));
endmodule

// File: rtl/lpc_bm_arbiter.sv
module lpc_bm_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pend,
  input  logic       fsm_idle,
  input  logic       host_busy,
  output logic       grant_fire,
  output logic       grant_idx,
  output logic [1:0] gnt
);
  logic ptr;
  logic contend;

  assign contend    = &pend;
  assign grant_fire = fsm_idle && !host_busy && (|pend);
  assign grant_idx  = contend ? ptr : pend[1];
  assign gnt        = grant_fire ? (grant_idx ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n)                     ptr <= 1'b0;
    else if (grant_fire && contend) ptr <= ~ptr;
  end

  p_gnt_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  p_rr_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_fire && contend) |=> (ptr != $past(ptr)));
  p_gnt_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> (pend[grant_idx] && fsm_idle));
endmodule

// File: rtl/lpc_bm_cycle.sv
module lpc_bm_cycle
  import lpc_bm_pkg::*;
#(
  parameter int ADDR_NIBBLES = 8,
  parameter logic [4*ADDR_NIBBLES-1:0] ADDR_LO = 32'h0010_0000,
  parameter logic [4*ADDR_NIBBLES-1:0] ADDR_HI = 32'h00FF_FFFF,
  parameter int ABORT_CYCLES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      grant_fire,
  input  logic                      grant_idx,
  input  logic                      host_busy,
  output logic                      fsm_idle,
  input  logic [3:0]                lad_in,
  output logic [3:0]                lad_out,
  output logic                      lad_oe,
  output logic                      lframe_n,
  output logic                      mem_valid,
  input  logic                      mem_ready,
  output logic                      mem_write,
  output logic [4*ADDR_NIBBLES-1:0] mem_addr,
  output logic [7:0]                mem_wdata,
  input  logic [7:0]                mem_rdata
);
  localparam int ADDR_W  = 4 * ADDR_NIBBLES;
  localparam int CNT_MAX = (ADDR_NIBBLES > ABORT_CYCLES) ? ADDR_NIBBLES : ABORT_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(ADDR_NIBBLES - 1);
  localparam logic [CNT_W-1:0] ABORT_LAST = CNT_W'(ABORT_CYCLES - 1);

  bm_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic              owner;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;
  logic [7:0]        rdata_q;
  logic              size_bad;

  assign size_bad = (lad_in != SIZE_BYTE) || (addr_q < ADDR_LO) || (addr_q > ADDR_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      owner   <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (grant_fire) begin
          owner <= grant_idx;
          state <= ST_START;
        end
        ST_START: state <= ST_CYC;
        ST_CYC: begin
          cnt <= '0;
          if (lad_in == CT_MEM_RD || lad_in == CT_MEM_WR) begin
            wr_q  <= (lad_in == CT_MEM_WR);
            state <= ST_ADDR;
          end else begin
            state <= ST_ABORT;
          end
        end
        ST_ADDR: begin
          addr_q <= {addr_q[ADDR_W-5:0], lad_in};
          if (cnt == ADDR_LAST) begin
            cnt   <= '0;
            state <= ST_SIZE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SIZE: begin
          cnt <= '0;
          if (size_bad)  state <= ST_ABORT;
          else if (wr_q) state <= ST_WDATA;
          else           state <= ST_MEM;
        end
        ST_WDATA: begin
          if (cnt == '0) begin
            wdata_q[3:0] <= lad_in;
            cnt          <= cnt + 1'b1;
          end else begin
            wdata_q[7:4] <= lad_in;
            cnt          <= '0;
            state        <= ST_MEM;
          end
        end
        ST_MEM: if (mem_ready) begin
          cnt <= '0;
          if (wr_q) begin
            state <= ST_SYNC;
          end else begin
            rdata_q <= mem_rdata;
            state   <= ST_RDATA;
          end
        end
        ST_RDATA: begin
          if (cnt == '0) cnt <= cnt + 1'b1;
          else begin
            cnt   <= '0;
            state <= ST_SYNC;
          end
        end
        ST_SYNC: state <= ST_IDLE;
        ST_ABORT: begin
          if (cnt == ABORT_LAST) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    lad_out = NIB_SYNC_OK;
    case (state)
      ST_START: lad_out = {START_HI, owner};
      ST_ABORT: lad_out = NIB_ABORT;
      ST_RDATA: lad_out = (cnt == '0) ? rdata_q[3:0] : rdata_q[7:4];
      default:  lad_out = NIB_SYNC_OK;
    endcase
  end

  assign fsm_idle  = (state == ST_IDLE);
  assign lframe_n  = !(state == ST_START || state == ST_ABORT);
  assign lad_oe    = (state == ST_START) || (state == ST_ABORT) ||
                     (state == ST_RDATA) || (state == ST_SYNC);
  assign mem_valid = (state == ST_MEM);
  assign mem_write = wr_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  p_start_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START) |-> !$past(host_busy));
  p_abort_no_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ABORT) |=> (state == ST_ABORT || state == ST_IDLE));
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_write) && $stable(mem_wdata)));
  p_sync_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SYNC) |=> (!lad_oe && lframe_n));
endmodule

// File: rtl/lpc_bm_host.sv
module lpc_bm_host
  import lpc_bm_pkg::*;
#(
  parameter int ADDR_NIBBLES = 8,
  parameter logic [4*ADDR_NIBBLES-1:0] ADDR_LO = 32'h0010_0000,
  parameter logic [4*ADDR_NIBBLES-1:0] ADDR_HI = 32'h00FF_FFFF,
  parameter int ABORT_CYCLES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                ldrq_n,
  input  logic                      host_busy,
  input  logic [3:0]                lad_in,
  output logic [3:0]                lad_out,
  output logic                      lad_oe,
  output logic                      lframe_n,
  output logic                      mem_valid,
  input  logic                      mem_ready,
  output logic                      mem_write,
  output logic [4*ADDR_NIBBLES-1:0] mem_addr,
  output logic [7:0]                mem_wdata,
  input  logic [7:0]                mem_rdata
);
  logic [1:0] pend;
  logic [1:0] gnt;
  logic       grant_fire;
  logic       grant_idx;
  logic       fsm_idle;

  for (genvar i = 0; i < 2; i++) begin : g_rx
    lpc_ldrq_rx u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .ldrq_n (ldrq_n[i]),
      .clr    (gnt[i]),
      .pend   (pend[i])
    );
  end

  lpc_bm_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend       (pend),
    .fsm_idle   (fsm_idle),
    .host_busy  (host_busy),
    .grant_fire (grant_fire),
    .grant_idx  (grant_idx),
    .gnt        (gnt)
  );

  lpc_bm_cycle #(
    .ADDR_NIBBLES (ADDR_NIBBLES),
    .ADDR_LO      (ADDR_LO),
    .ADDR_HI      (ADDR_HI),
    .ABORT_CYCLES (ABORT_CYCLES)
  ) u_cyc (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant_fire (grant_fire),
    .grant_idx  (grant_idx),
    .host_busy  (host_busy),
    .fsm_idle   (fsm_idle),
    .lad_in     (lad_in),
    .lad_out    (lad_out),
    .lad_oe     (lad_oe),
    .lframe_n   (lframe_n),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata)
  );

  p_reset_idle_r12: assert property (@(posedge clk) $past(!rst_n) |-> (lframe_n && !lad_oe && !mem_valid));
endmodule

// File: tb/tb_lpc_bm_host.sv
module tb_lpc_bm_host;
  localparam int CLK_PERIOD = 10;
  localparam int NIB = 4;
  localparam logic [15:0] LO = 16'h1000;
  localparam logic [15:0] HI = 16'h7FFF;
  localparam int ABORTS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ldrq_n = 2'b11;
  logic        host_busy = 1'b0;
  logic [3:0]  lad_in = 4'h0;
  logic [3:0]  lad_out;
  logic        lad_oe, lframe_n, mem_valid, mem_write;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  lpc_bm_host #(.ADDR_NIBBLES(NIB), .ADDR_LO(LO), .ADDR_HI(HI), .ABORT_CYCLES(ABORTS)) dut (
    .clk(clk), .rst_n(rst_n), .ldrq_n(ldrq_n), .host_busy(host_busy),
    .lad_in(lad_in), .lad_out(lad_out), .lad_oe(lad_oe), .lframe_n(lframe_n),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      summary();
    end
  end

  // R1 serial request: start 0, channel MSB first, action bit
  task automatic send_req(input int who, input logic [2:0] ch, input logic act);
    logic [4:0] bits;
    bits = {1'b0, ch, act};
    for (int k = 4; k >= 0; k--) begin
      @(negedge clk);
      ldrq_n[who] = bits[k];
    end
    @(negedge clk);
    ldrq_n[who] = 1'b1;
  endtask

  task automatic expect_quiet(input int n, input string req);
    bit seen;
    seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (!lframe_n) seen = 1'b1;
    end
    chk(!seen, req, {31'd0, seen}, 32'd0);
  endtask

  task automatic check_abort(input string req);
    for (int k = 0; k < ABORTS; k++) begin
      @(negedge clk);
      chk(!lframe_n && lad_oe && lad_out == 4'hF, req, {lframe_n, lad_oe, lad_out}, {1'b0, 1'b1, 4'hF});
    end
    lad_in = 4'h0;
    @(negedge clk);
    chk(lframe_n === 1'b1, "R9 idle after abort", {31'd0, lframe_n}, 32'd1);
  endtask

  // waits for the grant, checks START, then plays the master side of the cycle
  task automatic bm_body(input int who, input logic [3:0] cyc, input logic [15:0] addr,
                         input logic [3:0] size, input logic [7:0] wd, input logic [7:0] rd,
                         input int stall);
    int  guard;
    bit  wr;
    guard = 0;
    while (lframe_n !== 1'b0 && guard < 60) begin
      @(negedge clk);
      guard++;
    end
    chk(lframe_n === 1'b0 && lad_oe && lad_out == {3'b001, who[0]}, "R3 start code",
        {lad_oe, lad_out}, {1'b1, 3'b001, who[0]});
    @(negedge clk);
    chk(lframe_n === 1'b1, "R3 one-clock frame", {31'd0, lframe_n}, 32'd1);
    lad_in = cyc;
    if (!(cyc == 4'b0100 || cyc == 4'b0110)) begin
      check_abort("R6 bad cycle type aborts");
      return;
    end
    wr = (cyc == 4'b0110);
    for (int k = NIB - 1; k >= 0; k--) begin
      @(negedge clk);
      lad_in = addr[4*k +: 4];
    end
    @(negedge clk);
    lad_in = size;
    if (size != 4'h0) begin
      check_abort("R8 bad size aborts");
      return;
    end
    if (addr < LO || addr > HI) begin
      check_abort("R7 address outside window aborts");
      return;
    end
    if (wr) begin
      @(negedge clk);
      lad_in = wd[3:0];
      @(negedge clk);
      lad_in = wd[7:4];
    end
    @(negedge clk);
    lad_in = 4'h0;
    for (int s = 0; s < stall; s++) begin
      chk(mem_valid && mem_addr == addr && mem_write == wr && (!wr || mem_wdata == wd),
          "R10 request held under back-pressure", {mem_valid, mem_write, mem_addr}, {1'b1, wr, addr});
      @(negedge clk);
    end
    chk(mem_valid && mem_addr == addr && mem_write == wr, "R10 memory request",
        {mem_valid, mem_write, mem_addr}, {1'b1, wr, addr});
    if (wr) chk(mem_wdata == wd, "R10 write byte", {24'd0, mem_wdata}, {24'd0, wd});
    mem_ready = 1'b1;
    mem_rdata = rd;
    @(negedge clk);
    mem_ready = 1'b0;
    chk(!mem_valid, "R10 valid drops after handshake", {31'd0, mem_valid}, 32'd0);
    if (!wr) begin
      chk(lad_oe && lad_out == rd[3:0], "R11 read low nibble", {lad_oe, lad_out}, {1'b1, rd[3:0]});
      @(negedge clk);
      chk(lad_oe && lad_out == rd[7:4], "R11 read high nibble", {lad_oe, lad_out}, {1'b1, rd[7:4]});
      @(negedge clk);
    end
    chk(lad_oe && lad_out == 4'h0 && lframe_n, "R11 sync", {lad_oe, lad_out}, {1'b1, 4'h0});
    @(negedge clk);
    chk(!lad_oe && lframe_n, "R11 release", {lframe_n, lad_oe}, {1'b1, 1'b0});
  endtask

  task automatic bm_cycle(input int who, input logic [3:0] cyc, input logic [15:0] addr,
                          input logic [3:0] size, input logic [7:0] wd, input logic [7:0] rd,
                          input int stall);
    send_req(who, 3'b100, 1'b1);
    bm_body(who, cyc, addr, size, wd, rd, stall);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(lframe_n && !lad_oe && !mem_valid, "R12 reset outputs",
        {lframe_n, lad_oe, mem_valid}, {1'b1, 1'b0, 1'b0});
    rst_n = 1'b1;
    expect_quiet(8, "R12 nothing pending after reset");

    // R6 sweep of every cycle-type code, alternating masters
    for (int c = 0; c < 16; c++)
      bm_cycle(c % 2, c[3:0], 16'h2000 + 16'(c * 37), 4'h0, 8'(c * 17 + 3), 8'(255 - c * 9), 0);

    // R7 window edges, read and write
    for (int w = 0; w < 2; w++) begin
      bm_cycle(0, w ? 4'b0110 : 4'b0100, LO - 16'd1, 4'h0, 8'hA5, 8'h5A, 0);
      bm_cycle(1, w ? 4'b0110 : 4'b0100, LO,         4'h0, 8'h3C, 8'hC3, 0);
      bm_cycle(0, w ? 4'b0110 : 4'b0100, HI,         4'h0, 8'h0F, 8'hF0, 0);
      bm_cycle(1, w ? 4'b0110 : 4'b0100, HI + 16'd1, 4'h0, 8'h11, 8'h22, 0);
    end

    // R8 every non-byte size aborts
    for (int s = 1; s < 16; s++)
      bm_cycle(s % 2, 4'b0100, 16'h4321, s[3:0], 8'h00, 8'h00, 0);

    // R10 back-pressure
    bm_cycle(0, 4'b0110, 16'h1234, 4'h0, 8'h96, 8'h00, 3);
    bm_cycle(1, 4'b0100, 16'h6789, 4'h0, 8'h00, 8'h69, 5);

    // R5 host_busy holds off a grant
    host_busy = 1'b1;
    send_req(0, 3'b100, 1'b1);
    expect_quiet(20, "R5 no grant while host busy");
    host_busy = 1'b0;
    bm_body(0, 4'b0100, 16'h1500, 4'h0, 8'h00, 8'h77, 0);

    // R2 other channel ignored; R1 withdrawal
    send_req(1, 3'b001, 1'b1);
    expect_quiet(20, "R2 other channel ignored");
    send_req(0, 3'b011, 1'b1);
    expect_quiet(20, "R2 other channel ignored");
    host_busy = 1'b1;
    send_req(1, 3'b100, 1'b1);
    send_req(1, 3'b100, 1'b0);
    host_busy = 1'b0;
    expect_quiet(20, "R1 withdrawn request");

    // R4 round robin: pointer starts at master 0
    host_busy = 1'b1;
    fork
      send_req(0, 3'b100, 1'b1);
      send_req(1, 3'b100, 1'b1);
    join
    host_busy = 1'b0;
    bm_body(0, 4'b0110, 16'h3000, 4'h0, 8'h12, 8'h00, 0);
    bm_body(1, 4'b0100, 16'h3001, 4'h0, 8'h00, 8'h34, 0);
    host_busy = 1'b1;
    fork
      send_req(0, 3'b100, 1'b1);
      send_req(1, 3'b100, 1'b1);
    join
    host_busy = 1'b0;
    bm_body(1, 4'b0100, 16'h3002, 4'h0, 8'h00, 8'h56, 0);
    bm_body(0, 4'b0110, 16'h3003, 4'h0, 8'h78, 8'h00, 0);

    // R9 abort blocks the other pending master until the idle clock
    host_busy = 1'b1;
    fork
      send_req(0, 3'b100, 1'b1);
      send_req(1, 3'b100, 1'b1);
    join
    host_busy = 1'b0;
    bm_body(0, 4'b0010, 16'h0000, 4'h0, 8'h00, 8'h00, 0);
    bm_body(1, 4'b0100, 16'h7000, 4'h0, 8'h00, 8'hBE, 0);

    summary();
  end
endmodule